// File: doc/BRIEF.md
# Serial DAC Sample Frame Writer

This block takes one 14-bit output sample at a time over a valid/ready handshake. It delivers each sample to an external serial DAC as one framed transfer. A transfer starts when the active-low frame line is pulled low. A divided serial clock then carries a 16-bit word on the data line, upper byte first. The sample sits right-aligned in that word, and the two spare top bits are zero. The frame line is then released, which makes the converter latch the new value onto its analog output. A one-cycle done pulse marks the end of the frame, including the idle gap that separates it from the next one.

The serial clock runs at the system clock divided by `CLK_DIV`, which is at least 2. Each bit occupies one serial period. The period opens with a rising serial edge, at which the data bit changes, and the converter samples on the falling edge at mid-period. The frame line is driven low for one full serial period before the first rising edge. After the last bit it stays high for one full serial period before the next sample can be taken. A sample offered while a frame is in flight is held off and taken once the current frame completes.

Top module: `dac_frame_tx`

## Requirements
- R1: `in_ready` is high only while idle. A sample is taken at a rising clock edge where `in_valid` and `in_ready` are both high, and `in_ready` stays low from that edge until the cycle after the `frame_done` pulse.
- R2: `dac_sync_n` goes low in the first cycle after acceptance. It stays low with `dac_sclk` low for `CLK_DIV` cycles, and `dac_sclk` first goes high `CLK_DIV` cycles after acceptance.
- R3: Each frame carries exactly 16 serial clock pulses. In every bit period of `CLK_DIV` system cycles, `dac_sclk` is high for the first `CLK_DIV/2` cycles and low for the rest.
- R4: The transmitted word is `{2'b00, sample[13:0]}`. It is sent MSB first, so bit 15 goes first, bits 15..8 form the first byte and bits 7..0 form the second.
- R5: `dac_sdo` changes only in the cycle where `dac_sclk` rises, and holds through the high phase and the falling edge.
- R6: `dac_sync_n` returns high right after the 16th bit period ends. Between frames it stays high for at least `CLK_DIV` cycles.
- R7: `frame_done` is a single-cycle pulse in cycle `18*CLK_DIV-1`, counting the first cycle after acceptance as cycle 0.
- R8: `dac_sclk` is low whenever `dac_sync_n` is high.
- R9: A sample held valid while the block is busy is not lost. It is accepted in the cycle after `frame_done`, and a frame carrying it follows.
- R10: While `rst_n` is low, and after it returns high, the outputs are `dac_sync_n`=1, `dac_sclk`=0, `in_ready`=1 and `frame_done`=0, and any frame in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can take a sample |
| in_sample | input | DATA_W | Sample value, right-aligned in the frame word |
| dac_sync_n | output | 1 | Active-low frame line; its rising edge latches the DAC |
| dac_sclk | output | 1 | Serial clock, idles low |
| dac_sdo | output | 1 | Serial data, MSB first |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
All outputs are decoded from registers, so every result appears in the cycle after the edge that caused it. The bench counts cycles from the accepting edge and expects the frame line low from cycle 0, the first serial rise at cycle `CLK_DIV`, and the done pulse at cycle `18*CLK_DIV-1`. It expects `in_ready` to rise in the cycle after that pulse. The bench drives and samples on falling system-clock edges, so every comparison looks at a settled registered value. It rebuilds the word by sampling data at each falling serial edge, as the converter would.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_GAP
    } tx_state_e;

endpackage

// File: rtl/dac_tx_phase.sv
// Serial-period phase counter: counts CLK_DIV system cycles per serial bit.
module dac_tx_phase #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic wrap,
    output logic hi
);
    localparam int PW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    typedef struct packed {
        logic [PW-1:0] cnt;
    } phase_t;

    phase_t ph_d, ph_q;

    assign wrap = run && (ph_q.cnt == PW'(DIV - 1));
    assign hi   = run && (ph_q.cnt < PW'(HALF));

    always_comb begin
        ph_d = ph_q;
        if (!run || wrap) begin
            ph_d.cnt = '0;
        end else begin
            ph_d.cnt = ph_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

endmodule

// File: rtl/dac_tx_shreg.sv
// Parallel-load, MSB-first shift register for the frame word.
module dac_tx_shreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         msb
);
    typedef struct packed {
        logic [W-1:0] word;
    } sr_t;

    sr_t sr_d, sr_q;

    assign msb = sr_q.word[W-1];

    always_comb begin
        sr_d = sr_q;
        if (load) begin
            sr_d.word = din;
        end else if (shift) begin
            sr_d.word = {sr_q.word[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

endmodule

// File: rtl/dac_frame_tx.sv
// Frame sequencer: frame line low, lead period, 16 bits, release, gap period.
module dac_frame_tx
    import dac_tx_pkg::*;
#(
    parameter int DATA_W  = 14,
    parameter int WORD_W  = 16,
    parameter int CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_sample,
    output logic              dac_sync_n,
    output logic              dac_sclk,
    output logic              dac_sdo,
    output logic              frame_done
);
    localparam int PAD = WORD_W - DATA_W;
    localparam int BW  = $clog2(WORD_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

    typedef struct packed {
        tx_state_e     st;
        logic [BW-1:0] bitn;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [WORD_W-1:0] frame_word;
    logic              ph_run;
    logic              ph_wrap;
    logic              ph_hi;
    logic              sr_load;
    logic              sr_shift;

    generate
        if (PAD > 0) begin : g_pad
            assign frame_word = {{PAD{1'b0}}, in_sample};
        end else begin : g_nopad
            assign frame_word = in_sample[WORD_W-1:0];
        end
    endgenerate

    assign ph_run = (ctl_q.st != ST_IDLE);

    dac_tx_phase #(
        .DIV (CLK_DIV)
    ) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ph_run),
        .wrap  (ph_wrap),
        .hi    (ph_hi)
    );

    dac_tx_shreg #(
        .W (WORD_W)
    ) u_shreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sr_load),
        .shift (sr_shift),
        .din   (frame_word),
        .msb   (dac_sdo)
    );

    always_comb begin
        ctl_d    = ctl_q;
        sr_load  = 1'b0;
        sr_shift = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    ctl_d.st   = ST_LEAD;
                    ctl_d.bitn = '0;
                    sr_load    = 1'b1;
                end
            end
            ST_LEAD: begin
                if (ph_wrap) begin
                    ctl_d.st = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (ph_wrap) begin
                    if (ctl_q.bitn == LAST_BIT) begin
                        ctl_d.st = ST_GAP;
                    end else begin
                        ctl_d.bitn = ctl_q.bitn + 1'b1;
                        sr_shift   = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (ph_wrap) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st   <= ST_IDLE;
            ctl_q.bitn <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign in_ready   = (ctl_q.st == ST_IDLE);
    assign dac_sync_n = (ctl_q.st == ST_IDLE) || (ctl_q.st == ST_GAP);
    assign dac_sclk   = (ctl_q.st == ST_SHIFT) && ph_hi;
    assign frame_done = (ctl_q.st == ST_GAP) && ph_wrap;

endmodule

// File: rtl/dac_frame_tx_chk.sv
module dac_frame_tx_chk #(
    parameter int WORD_W = 16
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic dac_sync_n,
    input logic dac_sclk,
    input logic dac_sdo,
    input logic frame_done
);
    logic [5:0] rise_cnt;
    logic       sclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_cnt  <= '0;
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= dac_sclk;
            if (in_valid && in_ready) begin
                rise_cnt <= '0;
            end else if (dac_sclk && !sclk_prev) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    AST_ACCEPT_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!dac_sync_n && !in_ready)); // R1
    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (dac_sync_n && !frame_done)); // R1
    AST_SIXTEEN_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_sync_n) |-> (rise_cnt == 6'(WORD_W))); // R3
    AST_SDO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_sync_n && $past(!dac_sync_n) && !$rose(dac_sclk)) |-> $stable(dac_sdo)); // R5
    AST_DONE_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> dac_sync_n); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (!frame_done && in_ready)); // R7
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sync_n |-> !dac_sclk); // R8

endmodule

bind dac_frame_tx dac_frame_tx_chk #(
    .WORD_W (WORD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .dac_sync_n (dac_sync_n),
    .dac_sclk   (dac_sclk),
    .dac_sdo    (dac_sdo),
    .frame_done (frame_done)
);

// File: tb/sim_dac_frame_tx.sv
module sim_dac_frame_tx;
    localparam int DW    = 14;
    localparam int WW    = 16;
    localparam int DIV   = 4;
    localparam int FRAME = 18 * DIV;
    localparam int NV    = 6;

    localparam logic [DW-1:0] VS [NV] = '{14'h3FFF, 14'h0000, 14'h2AAA, 14'h1555, 14'h2001, 14'h0123};
    localparam logic [WW-1:0] VW [NV] = '{16'h3FFF, 16'h0000, 16'h2AAA, 16'h1555, 16'h2001, 16'h0123};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_sample = '0;
    logic          in_ready, dac_sync_n, dac_sclk, dac_sdo, frame_done;

    int total = 0;
    int bad = 0;

    logic [WW-1:0] cap = '0;
    int falls = 0;
    int idle_sclk_bad = 0;
    int hi_run = 0;
    int min_gap = 1000;
    logic had_frame = 1'b0;
    logic sync_prev = 1'b1;

    always #10 clk = ~clk;

    dac_frame_tx #(.DATA_W(DW), .WORD_W(WW), .CLK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sample(in_sample), .dac_sync_n(dac_sync_n), .dac_sclk(dac_sclk),
        .dac_sdo(dac_sdo), .frame_done(frame_done)
    );

    // converter model: capture data at each falling serial edge
    always @(negedge dac_sclk) begin
        cap   = {cap[WW-2:0], dac_sdo};
        falls = falls + 1;
    end

    // mid-cycle monitor for idle serial clock and inter-frame gap
    always @(negedge clk) begin
        if (rst_n) begin
            if (dac_sync_n && dac_sclk) idle_sclk_bad = idle_sclk_bad + 1;
            if (dac_sync_n) begin
                hi_run = hi_run + 1;
            end else begin
                if (sync_prev && had_frame && hi_run < min_gap) min_gap = hi_run;
                had_frame = 1'b1;
                hi_run = 0;
            end
            sync_prev = dac_sync_n;
        end else begin
            hi_run = 0;
            had_frame = 1'b0;
            sync_prev = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // offer a sample; returns just after the accepting edge
    task automatic offer(input logic [DW-1:0] s, input bit keep);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = s;
        while (!in_ready) @(negedge clk);
        cap   = '0;
        falls = 0;
        @(posedge clk);
        #1;
        if (!keep) in_valid = 1'b0;
    endtask

    // follow one frame from the cycle after acceptance
    task automatic wait_frame(input logic [WW-1:0] expw, input string tag);
        int n = 0;
        int rb = 0;
        int lead_bad = 0;
        forever begin
            @(negedge clk);
            if (n < DIV && (dac_sclk || dac_sync_n)) lead_bad = lead_bad + 1;
            if (n == DIV && !dac_sclk) lead_bad = lead_bad + 1;
            if (frame_done) break;
            if (in_ready) rb = rb + 1;
            n = n + 1;
            if (n > 4 * FRAME) break;
        end
        chk(lead_bad == 0, {"R2 lead ", tag}, lead_bad, 0);
        chk(rb == 0, {"R1 ready busy ", tag}, rb, 0);
        chk(n == FRAME - 1, {"R7 done cycle ", tag}, n, FRAME - 1);
        chk(falls == WW, {"R3 edges ", tag}, falls, WW);
        chk(cap == expw, {"R4 word ", tag}, int'(cap), int'(expw));
        @(negedge clk);
        chk(in_ready && !frame_done, {"R1 ready back ", tag}, int'(in_ready), 1);
        cap   = '0;
        falls = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R10 reset state
        repeat (3) @(negedge clk);
        chk(dac_sync_n && !dac_sclk && in_ready && !frame_done, "R10 in reset",
            {dac_sync_n, dac_sclk, in_ready, frame_done}, 4'b1010);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(dac_sync_n && !dac_sclk && in_ready && !frame_done, "R10 after reset",
            {dac_sync_n, dac_sclk, in_ready, frame_done}, 4'b1010);

        // vector table: R2 R3 R4 R5 R7
        for (int i = 0; i < NV; i++) begin
            offer(VS[i], 1'b0);
            wait_frame(VW[i], $sformatf("vec%0d", i));
        end

        // R9 held-off sample, valid held through the busy frame
        offer(14'h0F0F, 1'b1);
        in_sample = 14'h30C3;
        wait_frame(16'h0F0F, "R9 first");
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        wait_frame(16'h30C3, "R9 second");

        // R8 idle with no sample offered
        begin
            int act = 0;
            for (int k = 0; k < 3 * DIV; k++) begin
                @(negedge clk);
                if (!dac_sync_n || dac_sclk || !in_ready) act = act + 1;
            end
            chk(act == 0, "R8 idle quiet", act, 0);
        end

        // R10 reset in mid-frame
        offer(14'h2222, 1'b0);
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(dac_sync_n && !dac_sclk && in_ready && !frame_done, "R10 mid-frame reset",
            {dac_sync_n, dac_sclk, in_ready, frame_done}, 4'b1010);
        rst_n = 1'b1;
        repeat (2 * DIV) @(negedge clk);
        offer(14'h1ABC, 1'b0);
        wait_frame(16'h1ABC, "R10 recover");

        chk(idle_sclk_bad == 0, "R8 sclk while idle", idle_sclk_bad, 0);
        chk(min_gap >= DIV, "R6 gap", min_gap, DIV);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule